// File: doc/BRIEF.md
# Fly-by Single-Cycle DMA Transfer Sequencer

This block runs one DMA channel in fly-by mode. Each transfer unit passes straight between memory and an I/O device within a single bus cycle. The channel is loaded with a setup pulse. The setup gives the direction, the unit size, the external bus width, the address stepping mode, a start address, a unit count, and the slow-access indications (wait mode or DRAM area). From then on the block drives the memory address, the memory read or write strobe, an I/O acknowledge, an enable strobe and the byte-lane enables. It produces one bus cycle for each unit while the device keeps its request high and the channel is enabled.

The length of each bus cycle comes from the slow-access setting and from the alignment of the unit. A ready input stretches the enable phase. A setup that cannot complete in one cycle (a word unit on a byte-wide bus) is refused with an error flag. When a byte unit on the 16-bit bus sits on the high lane, the block copies the byte across lanes: the source byte is captured and re-driven on the destination lane, because the I/O device always sits on the low lane.

Top module: `flyby_dma_seq`

## Requirements
- R1: A bus cycle lasts 1+i clocks, where i is 1 with cfg_wait and cfg_dram both low and 2 otherwise. This applies to byte units at any address and to word units at even addresses.
- R2: A word unit (cfg_unit16=1) at an odd address on the 16-bit bus (cfg_bus16=1) lasts 2+i clocks.
- R3: A start with cfg_unit16=1 and cfg_bus16=0 sets cfg_err, leaves busy low and produces no bus cycle. An accepted start clears cfg_err.
- R4: cfg_amode selects the address stepping: 0 fixed, 1 forward, 2 backward, 3 fixed. The step is 1 for byte units and 2 for word units. mem_addr stays constant during a bus cycle and changes only at its end.
- R5: io_ack_n is low for the whole bus cycle. rd_n is low for the whole cycle when cfg_dir=0 (memory to I/O), and wr_n is low for the whole cycle when cfg_dir=1 (I/O to memory). en_n is low for only the final i clocks.
- R6: Each clock edge that sees ready low while en_n is low adds one clock to the enable phase. Ready is ignored outside the enable phase.
- R7: lane_n is active low, with bit 0 for data bits 7:0 and bit 1 for data bits 15:8. It is 2'b00 for a word unit on the 16-bit bus, 2'b10 on the 8-bit bus, and for a byte unit on the 16-bit bus it is 2'b10 at an even address and 2'b01 at an odd address.
- R8: For a byte unit on the 16-bit bus at an odd address, bus_doe is high while en_n is low. With cfg_dir=0, bus_dout[7:0] carries bus_din[15:8]. With cfg_dir=1, bus_dout[15:8] carries bus_din[7:0]. In every other case bus_doe stays low.
- R9: After cfg_count units, done goes high, busy goes low and mem_addr holds the address after the last step. done stays high until the next accepted start, which clears it. A start with a count of zero raises done at once.
- R10: A unit begins only while dreq and ch_en are both high in the armed state.
- R11: While reset is asserted, busy, done, cfg_err and bus_doe are low, and io_ack_n, rd_n, wr_n and en_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the setup and arm the channel (taken only when idle) |
| cfg_dir | input | 1 | 0 memory to I/O, 1 I/O to memory |
| cfg_unit16 | input | 1 | 1 word unit, 0 byte unit |
| cfg_bus16 | input | 1 | 1 16-bit external bus, 0 8-bit bus |
| cfg_amode | input | 2 | Address stepping mode |
| cfg_addr | input | 16 | Start memory address |
| cfg_count | input | 8 | Number of units |
| cfg_wait | input | 1 | Wait mode |
| cfg_dram | input | 1 | Address lies in the DRAM area |
| ch_en | input | 1 | Channel enable |
| dreq | input | 1 | Device request |
| ready | input | 1 | Ready; low stretches the enable phase |
| bus_din | input | 16 | Data bus as seen by the block |
| busy | output | 1 | Channel armed or transferring |
| done | output | 1 | All units transferred |
| cfg_err | output | 1 | Last start was refused |
| mem_addr | output | 16 | Memory address |
| io_ack_n | output | 1 | I/O acknowledge, active low |
| rd_n | output | 1 | Memory read strobe, active low |
| wr_n | output | 1 | Memory write strobe, active low |
| en_n | output | 1 | Enable strobe, active low |
| lane_n | output | 2 | Byte-lane enables, active low |
| bus_dout | output | 16 | Lane copy data |
| bus_doe | output | 1 | Drive enable for bus_dout |

## Verification
The assertions check the following on every clock: the read and write strobes are never both low, the enable sits inside the acknowledge, a ready-low enable clock is always followed by another enable clock, the address holds during a cycle, a refused setup leaves the channel idle, done and busy exclude each other, and the copy drive appears only inside the enable phase. Some properties can only be shown by the bench scenarios. These are the exact cycle length for each combination of wait mode, alignment and unit size, the enable width, the address sequence in each stepping mode, the lane pattern for each unit, the copied byte value, and the gating by request and channel enable.

// File: rtl/flyby_pkg.sv
package flyby_pkg;

  localparam int LEN_W = 3;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_FWD   = 2'd1,
    AM_BWD   = 2'd2,
    AM_HOLD  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CYC   = 2'd2
  } state_e;

  typedef struct packed {
    logic   dir;
    logic   u16;
    logic   b16;
    amode_e amode;
    logic   slow;
  } chan_cfg_t;

  // length of the enable phase: 1 fast, 2 slow
  function automatic logic [1:0] wait_term(input logic slow);
    return slow ? 2'd2 : 2'd1;
  endfunction

  // total clocks of one fly-by bus cycle
  function automatic logic [LEN_W-1:0] unit_len(input logic slow, input logic u16,
                                                input logic b16, input logic odd);
    logic [LEN_W-1:0] extra;
    extra = {{(LEN_W-1){1'b0}}, (u16 & b16 & odd)};
    return LEN_W'(1) + LEN_W'(wait_term(slow)) + extra;
  endfunction

  function automatic logic cfg_legal(input logic u16, input logic b16);
    return !(u16 && !b16);
  endfunction

  function automatic logic [1:0] step_size(input logic u16);
    return u16 ? 2'd2 : 2'd1;
  endfunction

  // active-low lane enables, bit0 = low byte
  function automatic logic [1:0] lane_pick(input logic u16, input logic b16,
                                           input logic odd);
    if (!b16)     return 2'b10;
    else if (u16) return 2'b00;
    else if (odd) return 2'b01;
    else          return 2'b10;
  endfunction

endpackage

// File: rtl/flyby_timer.sv
module flyby_timer
  import flyby_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       iterm,
  input  logic             ready,
  output logic             active,
  output logic             en_act,
  output logic             unit_end
);

  logic [LEN_W-1:0] rem_q;
  logic             hold;

  assign active   = (rem_q != '0);
  assign en_act   = active && (rem_q <= LEN_W'(iterm));
  assign hold     = en_act && !ready;
  assign unit_end = active && (rem_q == LEN_W'(1)) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (launch && !active) begin
      rem_q <= len;
    end else if (active && !hold) begin
      rem_q <= rem_q - LEN_W'(1);
    end
  end

endmodule

// File: rtl/flyby_addr.sv
module flyby_addr
  import flyby_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          advance,
  input  amode_e        amode,
  input  logic          u16,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] step;
  logic [AW-1:0] nxt;

  assign step = {{(AW-2){1'b0}}, step_size(u16)};
  assign last = (cnt_q == CW'(1));

  always_comb begin
    case (amode)
      AM_FWD:  nxt = addr + step;
      AM_BWD:  nxt = addr - step;
      default: nxt = addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      addr  <= load_addr;
      cnt_q <= load_cnt;
    end else if (advance) begin
      addr  <= nxt;
      cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/flyby_lanes.sv
module flyby_lanes
  import flyby_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                active,
  input  logic                en_act,
  input  logic                dir,
  input  logic                u16,
  input  logic                b16,
  input  logic                odd,
  input  logic [2*BYTE_W-1:0] din,
  output logic [1:0]          lane_n,
  output logic [2*BYTE_W-1:0] dout,
  output logic                doe
);

  localparam int DW = 2 * BYTE_W;

  logic             copy_case;
  logic [BYTE_W-1:0] src_byte;

  assign lane_n    = active ? lane_pick(u16, b16, odd) : 2'b11;
  assign copy_case = b16 && !u16 && odd;
  // memory sits on the high lane, device on the low lane
  assign src_byte  = dir ? din[BYTE_W-1:0] : din[DW-1:BYTE_W];
  assign doe       = copy_case && en_act;

  always_comb begin
    dout = '0;
    if (doe) begin
      if (dir) dout[DW-1:BYTE_W] = src_byte;
      else     dout[BYTE_W-1:0]  = src_byte;
    end
  end

endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
  import flyby_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CW     = 8,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cfg_dir,
  input  logic                cfg_unit16,
  input  logic                cfg_bus16,
  input  logic [1:0]          cfg_amode,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CW-1:0]       cfg_count,
  input  logic                cfg_wait,
  input  logic                cfg_dram,
  input  logic                ch_en,
  input  logic                dreq,
  input  logic                ready,
  input  logic [2*BYTE_W-1:0] bus_din,
  output logic                busy,
  output logic                done,
  output logic                cfg_err,
  output logic [AW-1:0]       mem_addr,
  output logic                io_ack_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic                en_n,
  output logic [1:0]          lane_n,
  output logic [2*BYTE_W-1:0] bus_dout,
  output logic                bus_doe
);

  state_e    st_q;
  chan_cfg_t cfg_q;
  logic      active, en_act, unit_end, last;
  logic      accept, refuse, launch, load;
  logic [LEN_W-1:0] len;

  // named events for the checker
  assign refuse = start && (st_q == ST_IDLE) && !cfg_legal(cfg_unit16, cfg_bus16);
  assign accept = start && (st_q == ST_IDLE) && cfg_legal(cfg_unit16, cfg_bus16);
  assign load   = accept && (cfg_count != '0);
  assign launch = (st_q == ST_ARMED) && dreq && ch_en;
  assign len    = unit_len(cfg_q.slow, cfg_q.u16, cfg_q.b16, mem_addr[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cfg_q   <= '0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (refuse) begin
            cfg_err <= 1'b1;
          end else if (accept) begin
            cfg_err <= 1'b0;
            cfg_q   <= '{dir: cfg_dir, u16: cfg_unit16, b16: cfg_bus16,
                         amode: amode_e'(cfg_amode), slow: cfg_wait | cfg_dram};
            if (cfg_count == '0) begin
              done <= 1'b1;
            end else begin
              done <= 1'b0;
              st_q <= ST_ARMED;
            end
          end
        end
        ST_ARMED: if (launch) st_q <= ST_CYC;
        ST_CYC: begin
          if (unit_end) begin
            if (last) begin
              st_q <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st_q <= ST_ARMED;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  flyby_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .len      (len),
    .iterm    (wait_term(cfg_q.slow)),
    .ready    (ready),
    .active   (active),
    .en_act   (en_act),
    .unit_end (unit_end)
  );

  flyby_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (cfg_addr),
    .load_cnt  (cfg_count),
    .advance   (unit_end),
    .amode     (cfg_q.amode),
    .u16       (cfg_q.u16),
    .addr      (mem_addr),
    .last      (last)
  );

  flyby_lanes #(.BYTE_W(BYTE_W)) u_lanes (
    .active (active),
    .en_act (en_act),
    .dir    (cfg_q.dir),
    .u16    (cfg_q.u16),
    .b16    (cfg_q.b16),
    .odd    (mem_addr[0]),
    .din    (bus_din),
    .lane_n (lane_n),
    .dout   (bus_dout),
    .doe    (bus_doe)
  );

  assign busy     = (st_q != ST_IDLE);
  assign io_ack_n = !active;
  assign rd_n     = !(active && !cfg_q.dir);
  assign wr_n     = !(active && cfg_q.dir);
  assign en_n     = !en_act;

endmodule

// File: rtl/flyby_dma_seq_chk.sv
module flyby_dma_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          cfg_unit16,
  input logic          cfg_bus16,
  input logic          ready,
  input logic          busy,
  input logic          done,
  input logic          cfg_err,
  input logic [AW-1:0] mem_addr,
  input logic          io_ack_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          en_n,
  input logic          bus_doe,
  input logic          unit_end
);

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_en_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_n |-> !io_ack_n);

  assert_ready_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !ready) |=> !en_n);

  assert_reject_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_unit16 && !cfg_bus16) |=> (cfg_err && !busy && io_ack_n));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_ack_n && !unit_end) |=> $stable(mem_addr));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_copy_in_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !en_n);

endmodule

bind flyby_dma_seq flyby_dma_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .cfg_unit16 (cfg_unit16),
  .cfg_bus16  (cfg_bus16),
  .ready      (ready),
  .busy       (busy),
  .done       (done),
  .cfg_err    (cfg_err),
  .mem_addr   (mem_addr),
  .io_ack_n   (io_ack_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .en_n       (en_n),
  .bus_doe    (bus_doe),
  .unit_end   (unit_end)
);

// File: tb/flyby_dma_seq_tb.sv
module flyby_dma_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cfg_dir = 1'b0, cfg_unit16 = 1'b0, cfg_bus16 = 1'b0;
  logic [1:0]  cfg_amode = 2'd0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_count = '0;
  logic        cfg_wait = 1'b0, cfg_dram = 1'b0, ch_en = 1'b1, dreq = 1'b0, ready = 1'b1;
  logic [15:0] bus_din = '0;
  logic        busy, done, cfg_err, io_ack_n, rd_n, wr_n, en_n, bus_doe;
  logic [15:0] mem_addr, bus_dout;
  logic [1:0]  lane_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  flyby_dma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dir(cfg_dir),
    .cfg_unit16(cfg_unit16), .cfg_bus16(cfg_bus16), .cfg_amode(cfg_amode),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_wait(cfg_wait),
    .cfg_dram(cfg_dram), .ch_en(ch_en), .dreq(dreq), .ready(ready),
    .bus_din(bus_din), .busy(busy), .done(done), .cfg_err(cfg_err),
    .mem_addr(mem_addr), .io_ack_n(io_ack_n), .rd_n(rd_n), .wr_n(wr_n),
    .en_n(en_n), .lane_n(lane_n), .bus_dout(bus_dout), .bus_doe(bus_doe)
  );

  typedef struct packed {
    logic        dir;
    logic        u16;
    logic        b16;
    logic [1:0]  am;
    logic [15:0] addr;
    logic [7:0]  cnt;
    logic        wt;
    logic        dr;
    logic [2:0]  len;
    logic [1:0]  iw;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 2'd1, 16'h0100, 8'd3, 1'b0, 1'b0, 3'd2, 2'd1},
    '{1'b1, 1'b1, 1'b1, 2'd1, 16'h0200, 8'd2, 1'b1, 1'b0, 3'd3, 2'd2},
    '{1'b0, 1'b1, 1'b1, 2'd2, 16'h0301, 8'd2, 1'b0, 1'b0, 3'd3, 2'd1},
    '{1'b1, 1'b0, 1'b0, 2'd2, 16'h0010, 8'd3, 1'b0, 1'b1, 3'd3, 2'd2},
    '{1'b0, 1'b1, 1'b1, 2'd0, 16'h0401, 8'd2, 1'b0, 1'b1, 3'd4, 2'd2},
    '{1'b1, 1'b0, 1'b1, 2'd1, 16'h0005, 8'd2, 1'b1, 1'b0, 3'd3, 2'd2},
    '{1'b0, 1'b1, 1'b1, 2'd1, 16'h0000, 8'd1, 1'b0, 1'b0, 3'd2, 2'd1},
    '{1'b1, 1'b1, 1'b1, 2'd1, 16'h0011, 8'd2, 1'b1, 1'b0, 3'd4, 2'd2}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step_addr(input logic [15:0] a, input logic [1:0] am,
                                            input logic u16);
    logic [15:0] s;
    s = u16 ? 16'd2 : 16'd1;
    if (am == 2'd1) return a + s;
    if (am == 2'd2) return a - s;
    return a;
  endfunction

  function automatic logic [1:0] exp_lane(input logic u16, input logic b16, input logic odd);
    if (!b16) return 2'b10;
    if (u16)  return 2'b00;
    return odd ? 2'b01 : 2'b10;
  endfunction

  task automatic setup(input logic dir, input logic u16, input logic b16,
                       input logic [1:0] am, input logic [15:0] a, input logic [7:0] n,
                       input logic wt, input logic dr);
    @(negedge clk);
    cfg_dir = dir; cfg_unit16 = u16; cfg_bus16 = b16; cfg_amode = am;
    cfg_addr = a; cfg_count = n; cfg_wait = wt; cfg_dram = dr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [15:0] ta;
    int units, run, enc;
    bit fin;
    ta = v.addr; units = 0; run = 0; enc = 0; fin = 0;
    dreq = 1'b1;
    setup(v.dir, v.u16, v.b16, v.am, v.addr, v.cnt, v.wt, v.dr);
    chk(done == 1'b0 && cfg_err == 1'b0, $sformatf("R9 R3 flags cleared by start v%0d", idx),
        {done, cfg_err}, 0);
    for (int k = 0; k < 200 && !fin; k++) begin
      @(negedge clk);
      if (!io_ack_n) begin
        if (run == 0) begin
          chk(mem_addr == ta, $sformatf("R4 address v%0d u%0d", idx, units), mem_addr, ta);
          chk(lane_n == exp_lane(v.u16, v.b16, ta[0]), $sformatf("R7 lanes v%0d", idx),
              lane_n, exp_lane(v.u16, v.b16, ta[0]));
          chk(rd_n == v.dir && wr_n == !v.dir, $sformatf("R5 strobes v%0d", idx),
              {rd_n, wr_n}, {v.dir, !v.dir});
        end
        run++;
        if (!en_n) enc++;
      end else if (run != 0) begin
        chk(run == int'(v.len), $sformatf("R1 R2 cycle length v%0d", idx), run, v.len);
        chk(enc == int'(v.iw), $sformatf("R5 enable width v%0d", idx), enc, v.iw);
        units++;
        ta = step_addr(ta, v.am, v.u16);
        run = 0; enc = 0;
        if (units == int'(v.cnt)) fin = 1;
      end
    end
    chk(units == int'(v.cnt), $sformatf("R9 unit count v%0d", idx), units, v.cnt);
    chk(done && !busy, $sformatf("R9 done idle v%0d", idx), {done, busy}, 2'b10);
    chk(mem_addr == ta, $sformatf("R4 final address v%0d", idx), mem_addr, ta);
    dreq = 1'b0;
  endtask

  task automatic copy_test(input logic dir, input logic [15:0] a, input logic [15:0] din,
                           input logic exp_doe, input logic [15:0] exp_out);
    int seen;
    bit fin;
    seen = 0; fin = 0;
    bus_din = din;
    dreq = 1'b1;
    setup(dir, 1'b0, 1'b1, 2'd0, a, 8'd1, 1'b0, 1'b0);
    for (int k = 0; k < 40 && !fin; k++) begin
      @(negedge clk);
      if (!en_n) begin
        seen++;
        chk(bus_doe == exp_doe, "R8 copy drive enable", bus_doe, exp_doe);
        if (exp_doe) chk(bus_dout == exp_out, "R8 copied byte", bus_dout, exp_out);
      end
      if (done) fin = 1;
    end
    chk(seen == 1, "R8 enable clocks in copy cycle", seen, 1);
    dreq = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int run, stall;
    bit fin;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cfg_err && !bus_doe, "R11 reset flags", {busy, done, cfg_err, bus_doe}, 0);
    chk(io_ack_n && rd_n && wr_n && en_n, "R11 reset strobes", {io_ack_n, rd_n, wr_n, en_n}, 4'hf);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R3 refused setup
    dreq = 1'b1;
    setup(1'b0, 1'b1, 1'b0, 2'd1, 16'h0800, 8'd2, 1'b0, 1'b0);
    chk(cfg_err && !busy, "R3 refused setup", {cfg_err, busy}, 2'b10);
    run = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!io_ack_n) run++;
    end
    chk(run == 0, "R3 no cycle after refusal", run, 0);
    dreq = 1'b0;

    // R10 gating by request and channel enable
    setup(1'b0, 1'b0, 1'b1, 2'd1, 16'h0900, 8'd1, 1'b0, 1'b0);
    run = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!io_ack_n) run++;
    end
    chk(run == 0 && busy, "R10 no cycle without request", run, 0);
    ch_en = 1'b0; dreq = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!io_ack_n) run++;
    end
    chk(run == 0 && mem_addr == 16'h0900, "R10 no cycle with channel disabled", run, 0);
    ch_en = 1'b1;
    fin = 0;
    for (int k = 0; k < 20 && !fin; k++) begin
      @(negedge clk);
      if (!io_ack_n) run++;
      if (done) fin = 1;
    end
    chk(run == 2 && done, "R10 cycle after enable", run, 2);
    dreq = 1'b0;

    // R6 ready stretch
    dreq = 1'b1;
    setup(1'b0, 1'b0, 1'b1, 2'd0, 16'h0040, 8'd1, 1'b0, 1'b0);
    run = 0; stall = 0; fin = 0;
    for (int k = 0; k < 40 && !fin; k++) begin
      @(negedge clk);
      if (!io_ack_n) begin
        run++;
        if (!en_n) begin
          if (stall < 3) begin ready = 1'b0; stall++; end
          else ready = 1'b1;
        end else begin
          ready = 1'b0; // outside the enable phase: ignored
        end
      end else if (run != 0) fin = 1;
    end
    ready = 1'b1;
    chk(run == 5, "R6 stretched cycle length", run, 5);
    dreq = 1'b0;

    // R8 lane copy
    copy_test(1'b1, 16'h0005, 16'h00C3, 1'b1, 16'hC300);
    copy_test(1'b0, 16'h0007, 16'h5A00, 1'b1, 16'h005A);
    copy_test(1'b0, 16'h0006, 16'h5A00, 1'b0, 16'h0000);

    // R9 zero count
    setup(1'b0, 1'b0, 1'b1, 2'd1, 16'h0A00, 8'd0, 1'b0, 1'b0);
    chk(done && !busy, "R9 zero count done", {done, busy}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule